// File: doc/BRIEF.md
# Multi-Pattern Transmit Test Word Generator

This block feeds the parallel transmit path of a serial link under test. Each enabled clock it emits one parallel word, `W` bits wide (20 by default). The word carries the next `W` consecutive bits of a serial test sequence. A run-time select input picks the sequence: one of four pseudo-random binary sequences of different lengths, a fast square wave that toggles every bit, or a slow square wave of ten ones then ten zeros. Changing the pattern needs no rebuild of the logic.

Every PRBS register advances a full word of bit-steps in one clock. Bit 0 of each word is the first bit in serial order. The square-wave phase counts serial bits rather than words, so the slow square wave keeps its 20-bit period for any word width. When the selected pattern changes, the next word starts the new sequence from its fixed all-ones seed, or from phase zero for the square waves.

Top module: `tx_pattern_gen`

## Requirements
- R1: `pat_sel` picks the pattern: code 0 is PRBS x^7+x^6+1, code 1 is x^15+x^14+1, code 2 is x^23+x^18+1, code 3 is x^31+x^28+1, code 4 is the toggle square wave, code 5 is the ten-ones/ten-zeros wave, and codes 6 and 7 give all-zero words.
- R2: A PRBS of order N with tap T steps as follows: feedback f = s[N-1] xor s[T-1], the state becomes {s[N-2:0], f}, and the serial output bit is f. Word bit i holds the i-th bit in serial order (bit 0 is first).
- R3: A cycle with `en` high produces one word. It appears on `data_out` after the next rising edge, and `valid_out` is high for exactly that cycle. `valid_out` is low after any cycle with `en` low.
- R4: While `en` is low, `data_out` holds its value and no generator state advances. The next enabled word continues the sequence where it stopped.
- R5: An enabled word whose `pat_sel` differs from the select of the previous enabled word starts from the all-ones seed (PRBS) or from phase 0 (square waves). A change of `pat_sel` while `en` is low takes effect at the next enabled word.
- R6: While the select stays the same, consecutive enabled words carry consecutive serial bits with no gap or repeat.
- R7: Code 4 gives serial bit value 1 at even positions counted from phase 0 and 0 at odd positions, continuing across words of any width.
- R8: Code 5 gives serial bits 1 at phase positions 0 to 9 and 0 at positions 10 to 19 of a 20-bit period, continuing across words of any width. With W=20 each word is 20'h003FF.
- R9: Synchronous active-high `rst` clears `data_out` and `valid_out`, loads every PRBS register with all ones, clears the square phase and takes code 0 as the previous select.
- R10: The PRBS-7 sequence repeats every 127 bits. With W=20, word j+127 equals word j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Produce a word this cycle |
| pat_sel | input | 3 | Pattern code (see R1) |
| data_out | output | W | Registered parallel word, bit 0 first on the line |
| valid_out | output | 1 | High for the cycle after an enabled cycle |

## Verification
The hardest case to reach is a square-wave phase that does not line up with a word boundary. The bench brings it out with a second instance built with an odd width of 7, driven in parallel with the 20-bit instance. Long runs of the slow square wave then show the period carried across words. The bench also reaches the seed reload that follows a select change made while `en` was low: it toggles the select during enable gaps and returns to an earlier PRBS that had been partly advanced. A 128-word run of PRBS-7 confirms that the sequence period closes.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  localparam int SEL_W    = 3;
  localparam int NUM_PRBS = 4;
  localparam int SQ_PERIOD = 20;
  localparam int SQ_HIGH   = 10;

  localparam logic [SEL_W-1:0] PAT_PRBS7  = 3'd0;
  localparam logic [SEL_W-1:0] PAT_PRBS15 = 3'd1;
  localparam logic [SEL_W-1:0] PAT_PRBS23 = 3'd2;
  localparam logic [SEL_W-1:0] PAT_PRBS31 = 3'd3;
  localparam logic [SEL_W-1:0] PAT_TOGGLE = 3'd4;
  localparam logic [SEL_W-1:0] PAT_SLOWSQ = 3'd5;

  function automatic int prbs_order(input int idx);
    case (idx)
      0:       return 7;
      1:       return 15;
      2:       return 23;
      default: return 31;
    endcase
  endfunction

  function automatic int prbs_tap(input int idx);
    case (idx)
      0:       return 6;
      1:       return 14;
      2:       return 18;
      default: return 28;
    endcase
  endfunction

endpackage

// File: rtl/tpg_lfsr_word.sv
// One Fibonacci LFSR advanced W bit-steps per enabled clock.
module tpg_lfsr_word #(
  parameter int ORDER = 7,
  parameter int TAP   = 6,
  parameter int W     = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         reload,
  output logic [W-1:0] word
);

  logic [ORDER-1:0] state;
  logic [ORDER-1:0] walk;
  logic             fb;

  // Unrolled W-step walk from either the held state or the seed.
  always_comb begin
    walk = reload ? {ORDER{1'b1}} : state;
    word = '0;
    fb   = 1'b0;
    for (int i = 0; i < W; i++) begin
      fb      = walk[ORDER-1] ^ walk[TAP-1];
      word[i] = fb;
      walk    = {walk[ORDER-2:0], fb};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= {ORDER{1'b1}};
    end else if (adv) begin
      state <= walk;
    end
  end

endmodule

// File: rtl/tpg_square.sv
// Square-wave source driven by a serial-bit phase counter.
module tpg_square #(
  parameter int W      = 20,
  parameter int PERIOD = 20,
  parameter int HIGH   = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         restart,
  output logic [W-1:0] toggle_word,
  output logic [W-1:0] slow_word
);

  localparam int PW = $clog2(PERIOD);
  localparam logic [PW-1:0] LAST  = PW'(PERIOD - 1);
  localparam logic [PW-1:0] HIGHV = PW'(HIGH);

  logic [PW-1:0] phase;
  logic [PW-1:0] p;

  always_comb begin
    p           = restart ? '0 : phase;
    toggle_word = '0;
    slow_word   = '0;
    for (int i = 0; i < W; i++) begin
      toggle_word[i] = ~p[0];
      slow_word[i]   = (p < HIGHV);
      p = (p == LAST) ? '0 : p + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (adv) begin
      phase <= p;
    end
  end

endmodule

// File: rtl/tx_pattern_gen.sv
module tx_pattern_gen
  import tpg_pkg::*;
#(
  parameter int W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] pat_sel,
  output logic [W-1:0]     data_out,
  output logic             valid_out
);

  logic [SEL_W-1:0] sel_q;
  logic             changed;
  logic [W-1:0]     prbs_words [NUM_PRBS];
  logic [W-1:0]     toggle_word;
  logic [W-1:0]     slow_word;
  logic [W-1:0]     next_word;
  logic             sq_adv;

  assign changed = (pat_sel != sel_q);
  assign sq_adv  = en && ((pat_sel == PAT_TOGGLE) || (pat_sel == PAT_SLOWSQ));

  for (genvar k = 0; k < NUM_PRBS; k++) begin : g_prbs
    tpg_lfsr_word #(
      .ORDER(prbs_order(k)),
      .TAP  (prbs_tap(k)),
      .W    (W)
    ) u_lfsr (
      .clk   (clk),
      .rst   (rst),
      .adv   (en && (pat_sel == SEL_W'(k))),
      .reload(changed),
      .word  (prbs_words[k])
    );
  end

  tpg_square #(
    .W     (W),
    .PERIOD(SQ_PERIOD),
    .HIGH  (SQ_HIGH)
  ) u_square (
    .clk        (clk),
    .rst        (rst),
    .adv        (sq_adv),
    .restart    (changed),
    .toggle_word(toggle_word),
    .slow_word  (slow_word)
  );

  always_comb begin
    case (pat_sel)
      PAT_PRBS7:  next_word = prbs_words[0];
      PAT_PRBS15: next_word = prbs_words[1];
      PAT_PRBS23: next_word = prbs_words[2];
      PAT_PRBS31: next_word = prbs_words[3];
      PAT_TOGGLE: next_word = toggle_word;
      PAT_SLOWSQ: next_word = slow_word;
      default:    next_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out  <= '0;
      valid_out <= 1'b0;
      sel_q     <= PAT_PRBS7;
    end else begin
      valid_out <= en;
      if (en) begin
        data_out <= next_word;
        sel_q    <= pat_sel;
      end
    end
  end

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
  parameter int W = 20
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic [2:0]   pat_sel,
  input logic [W-1:0] data_out,
  input logic         valid_out
);

  localparam logic [W-1:0] LOWMASK = {W{1'b1}} >> 1;

  // R9: reset clears outputs
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!valid_out && data_out == '0));

  // R3: valid follows enable by one cycle
  a_r3_valid_on_en: assert property (@(posedge clk) disable iff (rst)
    en |=> valid_out);
  a_r3_valid_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !valid_out);

  // R4: data held while disabled
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(data_out));

  // R1: unused codes give zero words
  a_r1_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (en && pat_sel[2:1] == 2'b11) |=> (data_out == '0));

  // R7: toggle pattern flips at every bit inside a word
  a_r7_toggle_flips: assert property (@(posedge clk) disable iff (rst)
    (en && pat_sel == 3'd4) |=> (((data_out ^ (data_out >> 1)) & LOWMASK) == LOWMASK));

  // R10: a PRBS-7 run of zeros is at most six bits long
  if (W >= 7) begin : g_p7
    a_r10_prbs7_nonzero: assert property (@(posedge clk) disable iff (rst)
      (en && pat_sel == 3'd0) |=> (data_out != '0));
  end

endmodule

bind tx_pattern_gen tpg_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .pat_sel  (pat_sel),
  .data_out (data_out),
  .valid_out(valid_out)
);

// File: tb/tb_tx_pattern_gen.sv
`timescale 1ns/1ps
module tb_tx_pattern_gen;

  localparam int WA = 20;
  localparam int WB = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en  = 1'b0;
  logic [2:0]    sel = 3'd0;
  logic [WA-1:0] da;
  logic [WB-1:0] db;
  logic          va, vb;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  tx_pattern_gen #(.W(WA)) dut (
    .clk(clk), .rst(rst), .en(en), .pat_sel(sel), .data_out(da), .valid_out(va));
  tx_pattern_gen #(.W(WB)) dut_odd (
    .clk(clk), .rst(rst), .en(en), .pat_sel(sel), .data_out(db), .valid_out(vb));

  // Reference model, serial bit by bit
  int          ORD [4] = '{7, 15, 23, 31};
  int          TAPS[4] = '{6, 14, 18, 28};
  logic [31:0] m_lfsr [2][4];
  int          m_phase[2];
  int          m_last [2];
  logic [31:0] exp_a, exp_b;

  function automatic logic [31:0] ord_mask(input int s);
    return (32'd1 << ORD[s]) - 32'd1;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      for (int s = 0; s < 4; s++) m_lfsr[k][s] = ord_mask(s);
      m_phase[k] = 0;
      m_last[k]  = 0;
    end
  endtask

  task automatic model_word(input int k, input int w, input int s, output logic [31:0] wd);
    logic [31:0] st;
    logic        fb;
    wd = '0;
    if (s != m_last[k]) begin
      m_phase[k] = 0;
      if (s < 4) m_lfsr[k][s] = ord_mask(s);
      m_last[k] = s;
    end
    for (int i = 0; i < w; i++) begin
      if (s < 4) begin
        st    = m_lfsr[k][s];
        fb    = st[ORD[s]-1] ^ st[TAPS[s]-1];
        wd[i] = fb;
        m_lfsr[k][s] = ((st << 1) | {31'd0, fb}) & ord_mask(s);
      end else if (s == 4 || s == 5) begin
        wd[i] = (s == 4) ? (m_phase[k] % 2 == 0) : (m_phase[k] < 10);
        m_phase[k] = (m_phase[k] + 1) % 20;
      end else begin
        wd[i] = 1'b0;
      end
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // One clock: drive at negedge, check after the edge
  task automatic cycle(input logic e, input logic [2:0] s, input string tag);
    @(negedge clk);
    en  = e;
    sel = s;
    if (e) begin
      model_word(0, WA, int'(s), exp_a);
      model_word(1, WB, int'(s), exp_b);
    end
    @(posedge clk);
    #1;
    chk(va === e && vb === e, "R3 valid", {30'd0, vb, va}, {30'd0, e, e});
    chk(da === exp_a[WA-1:0], {tag, " W20"}, {12'd0, da}, exp_a);
    chk(db === exp_b[WB-1:0], {tag, " W7"}, {25'd0, db}, exp_b);
  endtask

  logic [WA-1:0] first_p7;

  initial begin
    model_reset();
    exp_a = '0;
    exp_b = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(da === '0 && va === 1'b0, "R9 reset W20", {11'd0, va, da}, 32'd0);
    chk(db === '0 && vb === 1'b0, "R9 reset W7", {24'd0, vb, db}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R9/R2: PRBS-7 straight from the reset seed
    for (int i = 0; i < 12; i++) cycle(1'b1, 3'd0, "R9 R2 prbs7");
    // R1/R6: each longer PRBS in a continuous run
    for (int s = 1; s < 4; s++)
      for (int i = 0; i < 40; i++) cycle(1'b1, 3'(s), "R1 R6 prbs");
    // R4: enable gaps on PRBS-15
    for (int i = 0; i < 30; i++) cycle(i % 3 != 1, 3'd1, "R4 gaps");
    // R5: select changes while idle, then return to an earlier PRBS
    cycle(1'b0, 3'd2, "R5 idle change");
    cycle(1'b0, 3'd3, "R5 idle change");
    cycle(1'b1, 3'd3, "R5 reload");
    cycle(1'b1, 3'd3, "R5 continue");
    cycle(1'b1, 3'd1, "R5 back to prbs15");
    cycle(1'b1, 3'd1, "R5 continue");
    // R7: toggle wave, odd width shows phase carry
    for (int i = 0; i < 10; i++) cycle(1'b1, 3'd4, "R7 toggle");
    // R8: slow square wave, with an idle gap in the middle
    for (int i = 0; i < 30; i++) cycle(i != 13, 3'd5, "R8 slowsq");
    chk(da === 20'h003FF, "R8 W20 word", {12'd0, da}, 32'h003FF);
    // R5: slow wave restarts at phase 0 after a switch
    cycle(1'b1, 3'd4, "R5 square switch");
    cycle(1'b1, 3'd5, "R5 square switch");
    for (int i = 0; i < 5; i++) cycle(1'b1, 3'd5, "R8 slowsq again");
    // R1: unused codes
    for (int i = 0; i < 3; i++) cycle(1'b1, 3'd6, "R1 code6");
    for (int i = 0; i < 3; i++) cycle(1'b1, 3'd7, "R1 code7");
    // R10: PRBS-7 period closes after 127 words of 20 bits
    cycle(1'b1, 3'd0, "R10 prbs7");
    first_p7 = da;
    for (int i = 0; i < 126; i++) cycle(1'b1, 3'd0, "R10 prbs7");
    cycle(1'b1, 3'd0, "R10 prbs7");
    chk(da === first_p7, "R10 period", {12'd0, da}, {12'd0, first_p7});
    // R9: reset mid-stream returns to seed
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b0;
    @(posedge clk);
    #1;
    chk(da === '0 && va === 1'b0, "R9 mid reset", {11'd0, va, da}, 32'd0);
    model_reset();
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) cycle(1'b1, 3'd0, "R9 reseeded");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule